// File: doc/BRIEF.md
# Fuse Program Request Validator

This block sits behind the program-address register of a one-time-programmable fuse controller. When software writes a target address, the block decides whether that single fuse bit may be blown. The address carries a physical array number, a row and a column. The block first turns the physical array number into a logical array index, leaving a gap where one physical array is missing. It then runs an ordered chain of permission checks. The first check that fails ends the request.

If every check passes, the block issues a one-cycle set-bit request to the fuse store, which turns the addressed bit to 1. In every case it then posts a one-cycle completion event with an error flag and a cause code, which go to the interrupt logic. The fuse store is modelled inside the block as three logical arrays of 64 rows by 32 bits. Two of its bits serve as sticky lock fuses for the checks: one protects the helper-data arrays and one protects a key region of array 0.

Top module: `fuse_pgm_validator`

## Requirements
- R1: The program address is decoded as array number in bits 12:11, row in bits 10:5 and column in bits 4:0. On a successful request, setArr, setRow and setCol carry the logical array, the row and the column (bit index within the array is row*32+column).
- R2: Physical array 0 maps to logical array 0, physical 2 to logical 1 and physical 3 to logical 2. Physical array 1 is rejected with cause 1, ahead of every other check.
- R3: With a valid array and regLock high, the request fails with cause 2, ahead of the enable check.
- R4: With a valid array, regLock low and pgmEnable low, the request fails with cause 3.
- R5: Once the helper lock fuse (logical array 0, row 21, column 30) is 1, requests to physical arrays 2 and 3 fail with cause 4. Requests to array 0 are not affected by this fuse.
- R6: Once the region lock fuse (logical array 0, row 22, column 1) is 1, requests to rows 24 through 31 of physical array 0 fail with cause 5. Other rows and other arrays are not affected.
- R7: A request that passes every check raises setReq for exactly one cycle, reports cause 0 with evtError low, and leaves the addressed fuse bit at 1.
- R8: Every accepted request gives exactly one cycle of evtValid. evtError is high exactly when the cause is non-zero.
- R9: When pgmWrEn is sampled at clock edge E0, evtValid and setReq are high between edges E1 and E2. The fuse store shows the new bit after E2.
- R10: A pgmWrEn that arrives while a request is being decided or posted is ignored. It produces no event and sets no bit.
- R11: Blowing a bit that is already 1 counts as a success and leaves the row unchanged. Fuse bits never return to 0 except through reset.
- R12: After reset, evtValid, setReq and evtCause are 0 and the fuse store reads all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pgmWrEn | input | 1 | Write strobe of the program-address register |
| pgmAddr | input | 13 | Program address: array, row, column |
| regLock | input | 1 | Register lock active |
| pgmEnable | input | 1 | Programming enable bit |
| setReq | output | 1 | One-cycle set-bit request to the fuse store |
| setArr | output | 2 | Logical array of the set request |
| setRow | output | 6 | Row of the set request |
| setCol | output | 5 | Column of the set request |
| evtValid | output | 1 | One-cycle completion event |
| evtError | output | 1 | Request failed (valid with evtValid) |
| evtCause | output | 3 | 0 ok, 1 bad array, 2 register lock, 3 disabled, 4 helper lock, 5 region lock |
| rdArr | input | 2 | Logical array of the fuse read port |
| rdRow | input | 6 | Row of the fuse read port |
| rdData | output | 32 | Row contents of the fuse store (0 for array 3) |

## Verification
The hardest state to reach is a blocked request caused by a lock fuse. That state exists only after an earlier request has itself blown the lock bit through the same port. So the directed part of the stimulus first programs rows 24 to 31 while they are still open. It then blows the region lock and the helper lock, and retries the same addresses against those locks, also combined with register lock and a disabled enable to check the priority order. After that, constrained random requests run from a fresh reset over all four physical array numbers. A reference copy of the fuse contents predicts each outcome, including the rare random hits on a lock bit.

// File: rtl/fpv_pkg.sv
package fpv_pkg;

  localparam int ARR_FIELD_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECIDE = 2'd1,
    ST_POST   = 2'd2
  } fsmStateT;

  typedef enum logic [2:0] {
    CAUSE_NONE        = 3'd0,
    CAUSE_BAD_ARRAY   = 3'd1,
    CAUSE_REG_LOCK    = 3'd2,
    CAUSE_PGM_OFF     = 3'd3,
    CAUSE_HELPER_LOCK = 3'd4,
    CAUSE_REGION_LOCK = 3'd5
  } failCauseT;

  typedef struct packed {
    logic capture;
    logic commit;
  } ctrlStrobeT;

endpackage

// File: rtl/fpv_datapath.sv
module fpv_datapath
  import fpv_pkg::*;
#(
  parameter int ROWS            = 64,
  parameter int COLS            = 32,
  parameter int NUM_ARR         = 3,
  parameter int REGION_ROW_LO   = 24,
  parameter int REGION_ROW_HI   = 31,
  parameter int HELPER_LOCK_ROW = 21,
  parameter int HELPER_LOCK_COL = 30,
  parameter int REGION_LOCK_ROW = 22,
  parameter int REGION_LOCK_COL = 1,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int ADDR_W = ARR_FIELD_W + ROW_W + COL_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobeT             strobe,
  input  logic [ADDR_W-1:0]      pgmAddr,
  output logic                   arrValid,
  output logic                   helperArr,
  output logic                   inRegion,
  output logic                   helperLockFuse,
  output logic                   regionLockFuse,
  output logic [ARR_FIELD_W-1:0] setArr,
  output logic [ROW_W-1:0]       setRow,
  output logic [COL_W-1:0]       setCol,
  input  logic [ARR_FIELD_W-1:0] rdArr,
  input  logic [ROW_W-1:0]       rdRow,
  output logic [COLS-1:0]        rdData
);

  localparam int WORDS  = NUM_ARR * ROWS;
  localparam int WORD_W = $clog2(WORDS);
  localparam logic [ROW_W-1:0] REGION_LO = ROW_W'(REGION_ROW_LO);
  localparam logic [ROW_W-1:0] REGION_HI = ROW_W'(REGION_ROW_HI);

  logic [ADDR_W-1:0]      capAddr;
  logic [ARR_FIELD_W-1:0] physArr;
  logic [ARR_FIELD_W-1:0] logArr;
  logic [ROW_W-1:0]       capRow;
  logic [COL_W-1:0]       capCol;
  logic [WORD_W-1:0]      capWord;
  logic [WORD_W-1:0]      rdWord;
  logic [COLS-1:0]        fuseMem [WORDS];

  // request address register, loaded only when the control accepts a write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capAddr <= '0;
    else if (strobe.capture) capAddr <= pgmAddr;
  end

  assign physArr = capAddr[ADDR_W-1 -: ARR_FIELD_W];
  assign capRow  = capAddr[COL_W +: ROW_W];
  assign capCol  = capAddr[COL_W-1:0];

  // physical-to-logical array remap: physical 1 is a hole
  always_comb begin
    arrValid  = 1'b1;
    helperArr = 1'b0;
    logArr    = '0;
    unique case (physArr)
      2'd0: logArr = 2'd0;
      2'd2: begin logArr = 2'd1; helperArr = 1'b1; end
      2'd3: begin logArr = 2'd2; helperArr = 1'b1; end
      default: arrValid = 1'b0;
    endcase
  end

  assign inRegion = (physArr == 2'd0) && (capRow >= REGION_LO) && (capRow <= REGION_HI);
  assign capWord  = WORD_W'(logArr) * WORD_W'(ROWS) + WORD_W'(capRow);

  // fuse store: cleared by reset for the verification model, bits only rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) fuseMem[w] <= '0;
    end else if (strobe.commit) begin
      fuseMem[capWord][capCol] <= 1'b1;
    end
  end

  assign helperLockFuse = fuseMem[HELPER_LOCK_ROW][HELPER_LOCK_COL];
  assign regionLockFuse = fuseMem[REGION_LOCK_ROW][REGION_LOCK_COL];

  assign setArr = logArr;
  assign setRow = capRow;
  assign setCol = capCol;

  assign rdWord = WORD_W'(rdArr) * WORD_W'(ROWS) + WORD_W'(rdRow);
  assign rdData = (rdArr < ARR_FIELD_W'(NUM_ARR)) ? fuseMem[rdWord] : '0;

  // R7: a committed request leaves its target bit at 1 on the next cycle
  p_bit_blown_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> fuseMem[capWord][capCol]);

  // R11: lock fuses never fall back to 0
  p_helper_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    helperLockFuse |=> helperLockFuse);

  p_region_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    regionLockFuse |=> regionLockFuse);

endmodule

// File: rtl/fpv_ctrl.sv
module fpv_ctrl
  import fpv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pgmWrEn,
  input  logic       regLock,
  input  logic       pgmEnable,
  input  logic       arrValid,
  input  logic       helperArr,
  input  logic       inRegion,
  input  logic       helperLockFuse,
  input  logic       regionLockFuse,
  output ctrlStrobeT strobe,
  output logic       evtValid,
  output logic       evtError,
  output logic [2:0] evtCause
);

  fsmStateT  state;
  failCauseT causeQ;
  failCauseT verdict;

  // ordered permission chain; first failing check wins
  always_comb begin
    if (!arrValid)                      verdict = CAUSE_BAD_ARRAY;
    else if (regLock)                   verdict = CAUSE_REG_LOCK;
    else if (!pgmEnable)                verdict = CAUSE_PGM_OFF;
    else if (helperArr && helperLockFuse) verdict = CAUSE_HELPER_LOCK;
    else if (inRegion && regionLockFuse)  verdict = CAUSE_REGION_LOCK;
    else                                verdict = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      causeQ <= CAUSE_NONE;
    end else begin
      unique case (state)
        ST_IDLE:   if (pgmWrEn) state <= ST_DECIDE;
        ST_DECIDE: begin
          causeQ <= verdict;
          state  <= ST_POST;
        end
        ST_POST:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign strobe.capture = (state == ST_IDLE) && pgmWrEn;
  assign strobe.commit  = (state == ST_POST) && (causeQ == CAUSE_NONE);
  assign evtValid       = (state == ST_POST);
  assign evtError       = evtValid && (causeQ != CAUSE_NONE);
  assign evtCause       = evtValid ? causeQ : CAUSE_NONE;

  // R8: one event cycle per request
  p_single_event_r8: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> !evtValid);

  // R7: a commit is always reported as a clean completion
  p_commit_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> (evtValid && !evtError));

  // R9: event appears two edges after the accepted write
  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !evtValid ##1 evtValid);

  // R2: a hole in the array map is reported ahead of every lock
  p_bad_array_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECIDE && !arrValid) |=> (evtCause == CAUSE_BAD_ARRAY && !strobe.commit));

  // R3: register lock blocks every valid-array request
  p_reg_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECIDE && arrValid && regLock) |=> (evtCause == CAUSE_REG_LOCK));

endmodule

// File: rtl/fuse_pgm_validator.sv
module fuse_pgm_validator
  import fpv_pkg::*;
#(
  parameter int ROWS            = 64,
  parameter int COLS            = 32,
  parameter int NUM_ARR         = 3,
  parameter int REGION_ROW_LO   = 24,
  parameter int REGION_ROW_HI   = 31,
  parameter int HELPER_LOCK_ROW = 21,
  parameter int HELPER_LOCK_COL = 30,
  parameter int REGION_LOCK_ROW = 22,
  parameter int REGION_LOCK_COL = 1,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int ADDR_W = ARR_FIELD_W + ROW_W + COL_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pgmWrEn,
  input  logic [ADDR_W-1:0]      pgmAddr,
  input  logic                   regLock,
  input  logic                   pgmEnable,
  output logic                   setReq,
  output logic [ARR_FIELD_W-1:0] setArr,
  output logic [ROW_W-1:0]       setRow,
  output logic [COL_W-1:0]       setCol,
  output logic                   evtValid,
  output logic                   evtError,
  output logic [2:0]             evtCause,
  input  logic [ARR_FIELD_W-1:0] rdArr,
  input  logic [ROW_W-1:0]       rdRow,
  output logic [COLS-1:0]        rdData
);

  ctrlStrobeT strobe;
  logic arrValid, helperArr, inRegion, helperLockFuse, regionLockFuse;

  fpv_ctrl ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .pgmWrEn        (pgmWrEn),
    .regLock        (regLock),
    .pgmEnable      (pgmEnable),
    .arrValid       (arrValid),
    .helperArr      (helperArr),
    .inRegion       (inRegion),
    .helperLockFuse (helperLockFuse),
    .regionLockFuse (regionLockFuse),
    .strobe         (strobe),
    .evtValid       (evtValid),
    .evtError       (evtError),
    .evtCause       (evtCause)
  );

  fpv_datapath #(
    .ROWS            (ROWS),
    .COLS            (COLS),
    .NUM_ARR         (NUM_ARR),
    .REGION_ROW_LO   (REGION_ROW_LO),
    .REGION_ROW_HI   (REGION_ROW_HI),
    .HELPER_LOCK_ROW (HELPER_LOCK_ROW),
    .HELPER_LOCK_COL (HELPER_LOCK_COL),
    .REGION_LOCK_ROW (REGION_LOCK_ROW),
    .REGION_LOCK_COL (REGION_LOCK_COL)
  ) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .pgmAddr        (pgmAddr),
    .arrValid       (arrValid),
    .helperArr      (helperArr),
    .inRegion       (inRegion),
    .helperLockFuse (helperLockFuse),
    .regionLockFuse (regionLockFuse),
    .setArr         (setArr),
    .setRow         (setRow),
    .setCol         (setCol),
    .rdArr          (rdArr),
    .rdRow          (rdRow),
    .rdData         (rdData)
  );

  assign setReq = strobe.commit;

endmodule

// File: tb/fuse_pgm_validator_tb.sv
module fuse_pgm_validator_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pgmWrEn = 1'b0;
  logic [12:0] pgmAddr = '0;
  logic        regLock = 1'b0;
  logic        pgmEnable = 1'b0;
  logic        setReq;
  logic [1:0]  setArr;
  logic [5:0]  setRow;
  logic [4:0]  setCol;
  logic        evtValid;
  logic        evtError;
  logic [2:0]  evtCause;
  logic [1:0]  rdArr = '0;
  logic [5:0]  rdRow = '0;
  logic [31:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  int unsigned seedInit;
  logic [31:0] model [192];

  always #2 clk = ~clk;

  fuse_pgm_validator dut_i (
    .clk(clk), .rstN(rstN), .pgmWrEn(pgmWrEn), .pgmAddr(pgmAddr),
    .regLock(regLock), .pgmEnable(pgmEnable), .setReq(setReq),
    .setArr(setArr), .setRow(setRow), .setCol(setCol),
    .evtValid(evtValid), .evtError(evtError), .evtCause(evtCause),
    .rdArr(rdArr), .rdRow(rdRow), .rdData(rdData)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] mkAddr(input int phys, input int row, input int col);
    return {2'(phys), 6'(row), 5'(col)};
  endfunction

  function automatic int logOf(input int phys);
    return (phys == 0) ? 0 : phys - 1;
  endfunction

  // expected cause from the requirements and the reference fuse copy
  function automatic int expCause(input logic [12:0] a, input logic lk, input logic en);
    int phys = int'(a[12:11]);
    int row  = int'(a[10:5]);
    if (phys == 1) return 1;
    if (lk) return 2;
    if (!en) return 3;
    if (phys >= 2 && model[21][30]) return 4;
    if (phys == 0 && row >= 24 && row <= 31 && model[22][1]) return 5;
    return 0;
  endfunction

  function automatic string tagOf(input int c);
    case (c)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic readRow(input int arr, input int row, input string req);
    rdArr = 2'(arr);
    rdRow = 6'(row);
    #1;
    chk(req, "row contents", rdData, model[arr*64 + row]);
  endtask

  task automatic runReq(input logic [12:0] a, input logic lk, input logic en);
    int ec;
    int phys = int'(a[12:11]);
    int row  = int'(a[10:5]);
    int col  = int'(a[4:0]);
    @(negedge clk);
    pgmAddr = a; regLock = lk; pgmEnable = en; pgmWrEn = 1'b1;
    @(negedge clk);
    pgmWrEn = 1'b0;
    ec = expCause(a, lk, en);
    chk("R9", "evtValid during decide", evtValid, 0);
    @(negedge clk);
    chk("R8", "evtValid", evtValid, 1);
    chk(tagOf(ec), "evtCause", evtCause, ec);
    chk("R8", "evtError", evtError, (ec != 0));
    chk("R7", "setReq", setReq, (ec == 0));
    if (ec == 0) begin
      chk("R1", "setArr", setArr, logOf(phys));
      chk("R1", "setRow", setRow, row);
      chk("R1", "setCol", setCol, col);
      model[logOf(phys)*64 + row][col] = 1'b1;
    end
    @(negedge clk);
    chk("R8", "evtValid after post", evtValid, 0);
    chk("R7", "setReq after post", setReq, 0);
    if (phys != 1) readRow(logOf(phys), row, (ec == 0) ? "R11" : tagOf(ec));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    pgmWrEn = 1'b0;
    for (int i = 0; i < 192; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    seedInit = $urandom(32'h1D5E_ED01);
    for (int i = 0; i < 192; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "evtValid", evtValid, 0);
    chk("R12", "setReq", setReq, 0);
    chk("R12", "evtCause", evtCause, 0);
    rstN = 1'b1;
    @(negedge clk);
    readRow(0, 21, "R12");
    readRow(0, 22, "R12");
    readRow(2, 63, "R12");

    // R1, R2: decode and remap
    runReq(mkAddr(0, 5, 7), 0, 1);
    runReq(mkAddr(2, 63, 31), 0, 1);
    runReq(mkAddr(3, 0, 0), 0, 1);
    runReq(mkAddr(1, 4, 4), 0, 1);
    runReq(mkAddr(1, 4, 4), 1, 0);
    // R3, R4 and their order
    runReq(mkAddr(0, 9, 2), 1, 0);
    runReq(mkAddr(2, 9, 2), 0, 0);
    // R11: re-blowing a set bit
    runReq(mkAddr(0, 5, 7), 0, 1);
    // R6: region lock
    runReq(mkAddr(0, 24, 3), 0, 1);
    runReq(mkAddr(0, 22, 1), 0, 1);
    runReq(mkAddr(0, 31, 0), 0, 1);
    runReq(mkAddr(0, 24, 3), 0, 1);
    runReq(mkAddr(0, 23, 0), 0, 1);
    runReq(mkAddr(0, 32, 6), 0, 1);
    runReq(mkAddr(2, 30, 8), 0, 1);
    runReq(mkAddr(0, 28, 9), 0, 0);
    // R5: helper-array lock
    runReq(mkAddr(2, 10, 4), 0, 1);
    runReq(mkAddr(0, 21, 30), 0, 1);
    runReq(mkAddr(2, 10, 5), 0, 1);
    runReq(mkAddr(3, 60, 1), 0, 1);
    runReq(mkAddr(0, 40, 12), 0, 1);
    runReq(mkAddr(3, 60, 1), 0, 0);
    runReq(mkAddr(3, 60, 1), 1, 1);

    // R10: writes during decide and post are ignored
    @(negedge clk);
    pgmAddr = mkAddr(0, 50, 1); regLock = 0; pgmEnable = 1; pgmWrEn = 1'b1;
    @(negedge clk);
    pgmAddr = mkAddr(0, 51, 2);
    @(negedge clk);
    chk("R10", "evtValid", evtValid, 1);
    chk("R10", "setRow", setRow, 50);
    pgmAddr = mkAddr(0, 52, 3);
    @(negedge clk);
    pgmWrEn = 1'b0;
    model[50][1] = 1'b1;
    chk("R10", "evtValid after post", evtValid, 0);
    repeat (3) begin
      @(negedge clk);
      chk("R10", "no extra event", evtValid, 0);
    end
    readRow(0, 50, "R10");
    readRow(0, 51, "R10");
    readRow(0, 52, "R10");

    // constrained random from a fresh store
    doReset();
    readRow(0, 21, "R12");
    for (int n = 0; n < 400; n++) begin
      int phys = int'($urandom % 4);
      int row  = int'($urandom % 64);
      int col  = int'($urandom % 32);
      logic lk = (($urandom % 8) == 0);
      logic en = (($urandom % 8) != 0);
      runReq(mkAddr(phys, row, col), lk, en);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule